// File: doc/BRIEF.md
# Instrument Status Byte and Service Request Generator

This block builds the eight-bit status byte of an IEEE 488.2-style instrument. Its inputs are single-bit summaries that other status groups have already filtered through their own enable masks. From these it forms the status byte, ANDs the byte with a host-written service request enable mask, and ORs the result into an unlatched master summary bit. The master summary is available on a port in the same cycle.

A rising edge of the master summary sets a latched request-for-service bit. That latch drives the service request line to the controller. Two kinds of read are supported, and they differ only in bit 6 of the returned byte:

- A **serial poll** returns the latched request bit in bit 6 and then clears the latch, which drops the service request line.
- A **status query** returns the live master summary in bit 6 and leaves all state unchanged.

Each read gives a one-cycle response strobe with the byte, one clock after the request.

Top module: `svc_status_byte`

## Requirements
- R1: Byte layout: bit 0 = second questionable summary, bit 1 = always 0, bit 2 = error queue not empty, bit 3 = questionable summary, bit 4 = message available, bit 5 = standard event summary, bit 6 = master summary or request bit (depending on the read), bit 7 = operation summary.
- R2: `mss_o` is combinational. In the same cycle it is the OR, over every byte bit except bit 6, of that bit ANDed with the matching enable bit.
- R3: Enable bit 6 has no effect on `mss_o`. An enable mask of 0x40 keeps `mss_o` low with all inputs high.
- R4: When `en_wr_i` is high at a clock edge, the enable register loads `en_data_i`. The new mask governs `mss_o` from the next cycle on.
- R5: A 0-to-1 change of the master summary between two consecutive cycles sets the request latch at that edge. `srq_o` is high from the following cycle until the latch is cleared.
- R6: A serial poll (`poll_i` high) produces `rsp_valid_o` one cycle later. The byte carries the latch value in bit 6 and the live bits elsewhere. The poll clears the latch, so `srq_o` falls.
- R7: A status query (`query_i` high) produces `rsp_valid_o` one cycle later. The byte carries the live master summary in bit 6. The query clears nothing, so `srq_o` is unchanged.
- R8: While the master summary stays high after a poll, no new request is raised. A new request needs the summary to fall and rise again.
- R9: If a poll and a summary rising edge occur in the same cycle, the response carries the old latch value (0) in bit 6, and the latch ends up set.
- R10: While `rst_n` is low at a clock edge, the enable mask and the latch are cleared. `srq_o` and `rsp_valid_o` are 0 and `mss_o` stays 0 whatever the inputs.
- R11: `rsp_valid_o` is high only in the cycle after a poll or a query. A poll and a query in the same cycle are answered as a poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sum_ques2_i | input | 1 | Second questionable group summary |
| sum_err_i | input | 1 | Error queue not empty |
| sum_ques_i | input | 1 | Questionable group summary |
| sum_mav_i | input | 1 | Output message available |
| sum_evt_i | input | 1 | Standard event group summary |
| sum_oper_i | input | 1 | Operation group summary |
| en_wr_i | input | 1 | Enable mask write strobe |
| en_data_i | input | 8 | Enable mask write data |
| poll_i | input | 1 | Serial poll request (destructive read of bit 6) |
| query_i | input | 1 | Status query request (non-destructive) |
| rsp_valid_o | output | 1 | Response byte valid strobe |
| rsp_data_o | output | 8 | Response byte |
| mss_o | output | 1 | Live master summary |
| srq_o | output | 1 | Service request line |

## Verification
The assertions check the following rules on every cycle:
- the latch is set on each summary rising edge;
- the latch is cleared by a poll that does not coincide with a rising edge;
- the latch is not re-armed without a rising edge;
- the enable mask loads on a write;
- bit 1 of every response is 0;
- a response appears only after a read request.

Only the bench scenarios can show the rest. These are:
- the placement of each summary bit;
- the different bit 6 contents of a poll and a query;
- the masking of enable bit 6;
- the suppression of repeat requests while the summary stays high;
- the coincident poll-and-edge case.

// File: rtl/svc_stat_pkg.sv
// Shared constants and types for the status byte block.
// Assumes an eight-bit status byte; bit positions are fixed by the
// instrument status model and decoded by the host.
package svc_stat_pkg;
    localparam int STB_W    = 8;
    localparam int B_QUES2  = 0;
    localparam int B_UNUSED = 1;
    localparam int B_ERR    = 2;
    localparam int B_QUES   = 3;
    localparam int B_MAV    = 4;
    localparam int B_EVT    = 5;
    localparam int B_SUM    = 6;
    localparam int B_OPER   = 7;
    localparam logic [STB_W-1:0] SELF_BIT = STB_W'(1) << B_SUM;

    typedef struct packed {
        logic oper;
        logic evt;
        logic mav;
        logic ques;
        logic err;
        logic ques2;
    } stb_src_t;

    typedef enum logic [1:0] {
        RD_NONE  = 2'd0,
        RD_POLL  = 2'd1,
        RD_QUERY = 2'd2
    } rd_kind_t;
endpackage

// File: rtl/svc_stat_enable.sv
// Service request enable mask register.
// Loads the host data on a write strobe; cleared by synchronous
// active-low reset. All bits are stored; bit 6 is dropped downstream.
module svc_stat_enable
    import svc_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [STB_W-1:0] data_i,
    output logic [STB_W-1:0] en_o
);
    logic [STB_W-1:0] en_q;

    // Hold the mask, replace it on a host write.
    always_ff @(posedge clk) begin
        if (!rst_n)    en_q <= '0;
        else if (wr_i) en_q <= data_i;
    end

    assign en_o = en_q;

    AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (en_q == $past(data_i)))
        else $error("enable mask not loaded"); // R4
endmodule

// File: rtl/svc_stat_summary.sv
// Status byte assembly and master summary.
// Places each filtered group summary at its fixed bit, forces the
// unused bit and bit 6 to zero in the live byte, and ORs the enabled
// bits into the master summary. Purely combinational apart from checks.
module svc_stat_summary
    import svc_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  stb_src_t         src_i,
    input  logic [STB_W-1:0] en_i,
    output logic [STB_W-1:0] live_o,
    output logic             mss_o
);
    logic [STB_W-1:0] live;
    logic [STB_W-1:0] gated;

    // Place group summaries at their byte positions.
    always_comb begin
        live           = '0;
        live[B_QUES2]  = src_i.ques2;
        live[B_ERR]    = src_i.err;
        live[B_QUES]   = src_i.ques;
        live[B_MAV]    = src_i.mav;
        live[B_EVT]    = src_i.evt;
        live[B_OPER]   = src_i.oper;
        live[B_UNUSED] = 1'b0;
    end

    // Per-bit enable gating; the summary bit never feeds itself.
    for (genvar i = 0; i < STB_W; i++) begin : g_gate
        if (i == B_SUM) begin : g_self
            assign gated[i] = 1'b0;
        end else begin : g_bit
            assign gated[i] = live[i] & en_i[i];
        end
    end

    assign mss_o  = |gated;
    assign live_o = live;

    AST_SELF_ENABLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_i & ~SELF_BIT) == '0) |-> !mss_o)
        else $error("summary raised by bit 6 enable"); // R3
endmodule

// File: rtl/svc_stat_rqs.sv
// Latched request-for-service bit and service request line.
// Sets on a rising edge of the master summary, clears on a serial
// poll; a coincident rising edge wins over the poll.
module svc_stat_rqs (
    input  logic clk,
    input  logic rst_n,
    input  logic mss_i,
    input  logic poll_i,
    output logic rqs_o
);
    logic mss_q;
    logic rqs_q;
    logic rise;

    assign rise = mss_i & ~mss_q;

    // Remember last cycle's summary for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) mss_q <= 1'b0;
        else        mss_q <= mss_i;
    end

    // Request latch: set on edge, clear on poll, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      rqs_q <= 1'b0;
        else if (rise)   rqs_q <= 1'b1;
        else if (poll_i) rqs_q <= 1'b0;
    end

    assign rqs_o = rqs_q;

    AST_SET_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (mss_i && !mss_q) |=> rqs_q)
        else $error("request not latched on edge"); // R5
    AST_POLL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_i && !(mss_i && !mss_q)) |=> !rqs_q)
        else $error("poll did not clear request"); // R6
    AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (!rqs_q && !(mss_i && !mss_q)) |=> !rqs_q)
        else $error("request raised without edge"); // R8
    AST_HOLD_UNTIL_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (rqs_q && !poll_i) |=> rqs_q)
        else $error("request dropped without poll"); // R5
endmodule

// File: rtl/svc_stat_resp.sv
// Read response register.
// Registers the byte one cycle after a read: live bits everywhere,
// bit 6 from the latch on a poll or from the live summary on a query.
// A poll has priority over a simultaneous query.
module svc_stat_resp
    import svc_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             poll_i,
    input  logic             query_i,
    input  logic [STB_W-1:0] live_i,
    input  logic             mss_i,
    input  logic             rqs_i,
    output logic             valid_o,
    output logic [STB_W-1:0] data_o
);
    rd_kind_t         kind;
    logic [STB_W-1:0] byte_d;
    logic             valid_q;
    logic [STB_W-1:0] data_q;

    // Classify the request, poll first.
    always_comb begin
        if (poll_i)       kind = RD_POLL;
        else if (query_i) kind = RD_QUERY;
        else              kind = RD_NONE;
    end

    // Pick the bit 6 source for the response byte.
    always_comb begin
        byte_d        = live_i;
        byte_d[B_SUM] = (kind == RD_POLL) ? rqs_i : mss_i;
    end

    // Capture the response and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= (kind != RD_NONE);
            if (kind != RD_NONE) data_q <= byte_d;
        end
    end

    assign valid_o = valid_q;
    assign data_o  = data_q;

    AST_BIT1_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> !data_q[B_UNUSED])
        else $error("unused bit set"); // R1
    AST_RESP_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> $past(poll_i || query_i))
        else $error("response without request"); // R11
endmodule

// File: rtl/svc_status_byte.sv
// Top level: status byte, master summary and service request.
// Assumes the group summary inputs are already enable-filtered and
// synchronous to clk. Reset is synchronous and active low.
module svc_status_byte
    import svc_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sum_ques2_i,
    input  logic             sum_err_i,
    input  logic             sum_ques_i,
    input  logic             sum_mav_i,
    input  logic             sum_evt_i,
    input  logic             sum_oper_i,
    input  logic             en_wr_i,
    input  logic [STB_W-1:0] en_data_i,
    input  logic             poll_i,
    input  logic             query_i,
    output logic             rsp_valid_o,
    output logic [STB_W-1:0] rsp_data_o,
    output logic             mss_o,
    output logic             srq_o
);
    stb_src_t         src;
    logic [STB_W-1:0] en_mask;
    logic [STB_W-1:0] live_byte;
    logic             mss;
    logic             rqs;

    assign src = '{oper: sum_oper_i, evt: sum_evt_i, mav: sum_mav_i,
                   ques: sum_ques_i, err: sum_err_i, ques2: sum_ques2_i};

    svc_stat_enable u_enable (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (en_wr_i),
        .data_i (en_data_i),
        .en_o   (en_mask)
    );

    svc_stat_summary u_summary (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src),
        .en_i   (en_mask),
        .live_o (live_byte),
        .mss_o  (mss)
    );

    svc_stat_rqs u_rqs (
        .clk    (clk),
        .rst_n  (rst_n),
        .mss_i  (mss),
        .poll_i (poll_i),
        .rqs_o  (rqs)
    );

    svc_stat_resp u_resp (
        .clk     (clk),
        .rst_n   (rst_n),
        .poll_i  (poll_i),
        .query_i (query_i),
        .live_i  (live_byte),
        .mss_i   (mss),
        .rqs_i   (rqs),
        .valid_o (rsp_valid_o),
        .data_o  (rsp_data_o)
    );

    assign mss_o = mss;
    assign srq_o = rqs;

    AST_SRQ_FALLS_ON_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (srq_o && poll_i && !mss) |=> !srq_o)
        else $error("service request held after poll"); // R6
endmodule

// File: tb/test_svc_status_byte.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task models the expected byte for each
// read and queues it; the monitor pops and compares on each response.
module test_svc_status_byte;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       s_q2 = 0, s_err = 0, s_q = 0, s_mav = 0, s_evt = 0, s_op = 0;
    logic       en_wr = 0;
    logic [7:0] en_data = '0;
    logic       poll = 0, query = 0;
    logic       rsp_valid;
    logic [7:0] rsp_data;
    logic       mss, srq;

    typedef struct { logic [7:0] d; string tag; } exp_t;
    exp_t exp_q[$];

    int   n_chk = 0;
    int   n_err = 0;
    logic run = 0;
    logic [7:0] en_m = '0;
    logic prev_m = 0, rqs_m = 0;

    always #2.5 clk = ~clk;

    svc_status_byte i_svc_status_byte (
        .clk(clk), .rst_n(rst_n),
        .sum_ques2_i(s_q2), .sum_err_i(s_err), .sum_ques_i(s_q),
        .sum_mav_i(s_mav), .sum_evt_i(s_evt), .sum_oper_i(s_op),
        .en_wr_i(en_wr), .en_data_i(en_data),
        .poll_i(poll), .query_i(query),
        .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
        .mss_o(mss), .srq_o(srq)
    );

    task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    // Live byte from the inputs, per the R1 layout.
    function automatic logic [7:0] live_m();
        return {s_op, 1'b0, s_evt, s_mav, s_q, s_err, 1'b0, s_q2};
    endfunction

    // Model summary per R2/R3.
    function automatic logic mss_m();
        return |(live_m() & en_m & 8'hBF);
    endfunction

    // One cycle: src = {oper,evt,mav,ques,err,ques2}.
    task automatic step(input logic [5:0] src, input logic wr, input logic [7:0] wd,
                        input logic p, input logic q, input string tag);
        logic m;
        logic [7:0] b;
        @(negedge clk);
        {s_op, s_evt, s_mav, s_q, s_err, s_q2} = src;
        en_wr = wr; en_data = wd; poll = p; query = q;
        #1;
        m = mss_m();
        chk(mss === m, tag, {7'd0, mss}, {7'd0, m});
        if (p || q) begin
            b = live_m();
            b[6] = p ? rqs_m : m;
            exp_q.push_back('{d: b, tag: tag});
        end
        @(posedge clk);
        if (m && !prev_m) rqs_m = 1'b1;
        else if (p)       rqs_m = 1'b0;
        prev_m = m;
        if (wr) en_m = wd;
    endtask

    // Monitor: check latch line and responses away from the edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (run) begin
                chk(srq === rqs_m, "R5/R6 srq", {7'd0, srq}, {7'd0, rqs_m});
                if (rsp_valid === 1'b1) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R11 unexpected response", rsp_data, 8'h00);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        chk(rsp_data === e.d, e.tag, rsp_data, e.d);
                    end
                end
            end
        end
    end

    initial begin
        #200000;
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // R10: reset with all inputs high and a pending write.
        {s_op, s_evt, s_mav, s_q, s_err, s_q2} = 6'h3F;
        en_wr = 1; en_data = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(srq === 1'b0, "R10 srq in reset", {7'd0, srq}, 8'h00);
        chk(rsp_valid === 1'b0, "R10 valid in reset", {7'd0, rsp_valid}, 8'h00);
        chk(mss === 1'b0, "R10 mss in reset", {7'd0, mss}, 8'h00);
        en_wr = 0;
        rst_n = 1;
        run = 1;
        step(6'h3F, 0, 8'h00, 0, 0, "R10 mask cleared");
        // R3: only bit 6 enabled.
        step(6'h3F, 1, 8'h40, 0, 0, "R4 write 40");
        step(6'h3F, 0, 8'h00, 0, 1, "R3 bit6 enable ignored");
        // R1: walk each source with mask off, query.
        for (int i = 0; i < 6; i++) step(6'(1 << i), 0, 8'h00, 0, 1, "R1 bit placement");
        // R2/R4/R5: enable error bit only.
        step(6'h00, 1, 8'h04, 0, 0, "R4 write 04");
        step(6'h3D, 0, 8'h00, 0, 0, "R2 masked inputs");
        step(6'h02, 0, 8'h00, 0, 0, "R5 rise");
        step(6'h02, 0, 8'h00, 0, 1, "R7 query keeps latch");
        step(6'h02, 0, 8'h00, 0, 0, "R7 after query");
        step(6'h02, 0, 8'h00, 1, 0, "R6 poll returns latch");
        // R8: summary stays high, no new request.
        step(6'h02, 0, 8'h00, 0, 0, "R8 held high");
        step(6'h02, 0, 8'h00, 0, 1, "R8 query live");
        step(6'h00, 0, 8'h00, 0, 0, "R8 fall");
        step(6'h02, 0, 8'h00, 0, 0, "R8 re-rise");
        // R9: clear, drop, then poll on the rising edge.
        step(6'h02, 0, 8'h00, 1, 0, "R6 clear");
        step(6'h00, 0, 8'h00, 0, 0, "R9 fall");
        step(6'h02, 0, 8'h00, 1, 0, "R9 poll with edge");
        step(6'h02, 0, 8'h00, 0, 0, "R9 latch set");
        // R11: poll and query together answered as poll.
        step(6'h02, 0, 8'h00, 1, 1, "R11 poll priority");
        // R2: full mask, all sources.
        step(6'h00, 1, 8'hFF, 0, 0, "R4 write FF");
        step(6'h20, 0, 8'h00, 0, 0, "R2 oper only");
        step(6'h3F, 0, 8'h00, 0, 1, "R1 full byte");
        step(6'h00, 0, 8'h00, 1, 0, "R6 poll low summary");
        step(6'h00, 0, 8'h00, 0, 0, "R11 idle");
        step(6'h00, 0, 8'h00, 0, 0, "R11 idle");
        @(negedge clk);
        chk(exp_q.size() == 0, "R11 missing response", 8'(exp_q.size()), 8'h00);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule